// File: doc/BRIEF.md
# Superpriority Interrupt Acceptance and Selection

This block decides which pending interrupt, if any, a processor core with several exception levels should take next. It forms the pending levels of seven interrupt classes from the physical request lines, the virtual request lines and the hypervisor's injection bits. It applies the core's status masks, the per-level control bits and the hypervisor routing bits to each class, and reports the first class that is pending and unmasked in a fixed priority order. A superpriority class (a physical NMI and two virtual NMI variants) ignores the ordinary I and F masks and answers only to a separate all-interrupt mask. When superpriority is switched off for the target level, each NMI-class request is handled as its ordinary counterpart instead.

The result is a registered exception code with a valid flag. The code is refreshed on every clock edge from the inputs of the previous cycle. Exception entry and vector generation take the code from there. Physical classes target the level given on `phys_tgt_lvl`. Virtual classes always target level 1.

Top module: `sprio_arb`

## Requirements
- R1: A physical class is never selected when `phys_tgt_lvl` < `cur_lvl`. A virtual class is never selected when `cur_lvl` > 1.
- R2: The all-interrupt mask for a target level T is active only when `HAS_NMI` = 1, `sp_en[T]` = 1 and `cur_lvl` = T. It is then set by `st_allint` = 1, or by `spm_en[T]` = 1 together with `st_spsel` = 1. T is `phys_tgt_lvl` for physical classes and 1 for virtual classes.
- R3: A physical NMI with superpriority on is taken whenever its all-interrupt mask is inactive, whatever `st_mask_i` and `st_mask_f` hold.
- R4: A physical IRQ needs `st_mask_i` = 0, and a physical FIQ needs `st_mask_f` = 0. Both also need the all-interrupt mask inactive.
- R5: A virtual IRQ-NMI needs `hyp_imo` = 1 and `hyp_tge` = 0. A virtual FIQ-NMI needs `hyp_fmo` = 1 and `hyp_tge` = 0. Both need the all-interrupt mask inactive, and neither depends on I or F.
- R6: A virtual IRQ needs `hyp_imo` = 1, `hyp_tge` = 0, `st_mask_i` = 0 and the all-interrupt mask inactive. A virtual FIQ needs the same with `hyp_fmo` and `st_mask_f`.
- R7: Among the unmasked pending classes, the first in this order wins: NMI, virtual IRQ-NMI, virtual FIQ-NMI, FIQ, IRQ, virtual IRQ, virtual FIQ.
- R8: The virtual IRQ-NMI level is (`hyp_vi` AND `hyp_vinmi`) OR `vinmi_line`. The virtual FIQ-NMI level is (`hyp_vf` AND `hyp_vfnmi`) OR `vfnmi_line`.
- R9: When `HAS_NMI` = 0 or `sp_en` of the target level is 0, an NMI request counts as an IRQ, a virtual IRQ-NMI as a virtual IRQ, and a virtual FIQ-NMI as a virtual FIQ, with those classes' masks.
- R10: When `hyp_vi` and `hyp_vinmi` are both 1 and superpriority is on, the injection raises only the virtual IRQ-NMI class, so the code is 2 and never 6. The FIQ pair behaves the same way and gives code 3.
- R11: `exc_code` and `exc_valid` are registered and follow the inputs one clock edge later. `exc_valid` = 1 exactly when `exc_code` is non-zero. The codes are: 0 none, 1 NMI, 2 virtual IRQ-NMI, 3 virtual FIQ-NMI, 4 FIQ, 5 IRQ, 6 virtual IRQ, 7 virtual FIQ. A low `rst_n` at a clock edge clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Physical NMI request line |
| irq_req | input | 1 | Physical IRQ request line |
| fiq_req | input | 1 | Physical FIQ request line |
| virq_line | input | 1 | Virtual IRQ line from the interrupt controller |
| vfiq_line | input | 1 | Virtual FIQ line from the interrupt controller |
| vinmi_line | input | 1 | Virtual IRQ-NMI line from the interrupt controller |
| vfnmi_line | input | 1 | Virtual FIQ-NMI line from the interrupt controller |
| cur_lvl | input | LW | Current exception level |
| phys_tgt_lvl | input | LW | Target level of physical interrupts |
| st_mask_i | input | 1 | Status I mask |
| st_mask_f | input | 1 | Status F mask |
| st_allint | input | 1 | Status all-interrupt mask bit |
| st_spsel | input | 1 | Status stack-select bit |
| sp_en | input | NLVL | Per-level superpriority enable |
| spm_en | input | NLVL | Per-level stack-pointer interrupt mask enable |
| hyp_imo | input | 1 | Route IRQs to hypervisor |
| hyp_fmo | input | 1 | Route FIQs to hypervisor |
| hyp_tge | input | 1 | Trap general exceptions to hypervisor level |
| hyp_vi | input | 1 | Hypervisor virtual IRQ injection |
| hyp_vf | input | 1 | Hypervisor virtual FIQ injection |
| hyp_vinmi | input | 1 | Mark injected virtual IRQ as superpriority |
| hyp_vfnmi | input | 1 | Mark injected virtual FIQ as superpriority |
| exc_code | output | 3 | Registered selected exception code |
| exc_valid | output | 1 | Registered flag: a code is selected |

## Verification
Every result is due one clock edge after the input pattern that causes it, because the only register lies between the selection logic and the outputs. The bench changes inputs on a falling edge. The rising edge that follows captures the result, and the bench compares the outputs on the next falling edge, before it applies another pattern. Reset clearing is checked the same way, one edge after `rst_n` goes low.

// File: rtl/sprio_pkg.sv
// Package: shared exception codes and candidate slot numbering.
// Slot order is the selection priority; code = slot + 1, 0 = none.
package sprio_pkg;
    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_NMI   = 3'd1,
        EXC_VINMI = 3'd2,
        EXC_VFNMI = 3'd3,
        EXC_FIQ   = 3'd4,
        EXC_IRQ   = 3'd5,
        EXC_VIRQ  = 3'd6,
        EXC_VFIQ  = 3'd7
    } exc_code_t;

    localparam int NUM_CAND  = 7;
    localparam int SLOT_NMI   = 0;
    localparam int SLOT_VINMI = 1;
    localparam int SLOT_VFNMI = 2;
    localparam int SLOT_FIQ   = 3;
    localparam int SLOT_IRQ   = 4;
    localparam int SLOT_VIRQ  = 5;
    localparam int SLOT_VFIQ  = 6;
endpackage

// File: rtl/sprio_gate.sv
// Module: sprio_gate
// Evaluates, for one target exception level, whether that level may be
// entered from the current level, whether superpriority is switched on
// there, and whether the all-interrupt mask is in force.
// Assumes: NLVL levels, levels encoded as unsigned numbers.
module sprio_gate #(
    parameter int NLVL    = 4,
    parameter bit HAS_NMI = 1'b1,
    localparam int LW     = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic [LW-1:0]   cur_lvl,
    input  logic [LW-1:0]   tgt_lvl,
    input  logic [NLVL-1:0] sp_en,
    input  logic [NLVL-1:0] spm_en,
    input  logic            st_allint,
    input  logic            st_spsel,
    output logic            lvl_ok,
    output logic            sp_on,
    output logic            all_mask
);
    // Level check, superpriority enable and all-interrupt mask for this target.
    always_comb begin
        lvl_ok   = (tgt_lvl >= cur_lvl);
        sp_on    = HAS_NMI && sp_en[tgt_lvl];
        all_mask = sp_on && (cur_lvl == tgt_lvl) &&
                   (st_allint || (spm_en[tgt_lvl] && st_spsel));
    end
endmodule

// File: rtl/sprio_pend.sv
// Module: sprio_pend
// Forms the pending level of each of the seven classes, merging hypervisor
// injection with the incoming lines, and folds NMI-class requests into their
// ordinary class when superpriority is off for their target.
// Assumes: slot numbering from sprio_pkg.
module sprio_pend
    import sprio_pkg::*;
(
    input  logic                nmi_req,
    input  logic                irq_req,
    input  logic                fiq_req,
    input  logic                virq_line,
    input  logic                vfiq_line,
    input  logic                vinmi_line,
    input  logic                vfnmi_line,
    input  logic                hyp_vi,
    input  logic                hyp_vf,
    input  logic                hyp_vinmi,
    input  logic                hyp_vfnmi,
    input  logic                sp_on_phys,
    input  logic                sp_on_virt,
    output logic [NUM_CAND-1:0] pend
);
    logic vinmi_lvl, virq_lvl, vfnmi_lvl, vfiq_lvl;

    // Injection: a superpriority-marked injection raises only the NMI variant.
    always_comb begin
        vinmi_lvl = (hyp_vi && hyp_vinmi) || vinmi_line;
        virq_lvl  = (hyp_vi && !hyp_vinmi) || virq_line;
        vfnmi_lvl = (hyp_vf && hyp_vfnmi) || vfnmi_line;
        vfiq_lvl  = (hyp_vf && !hyp_vfnmi) || vfiq_line;
    end

    // Slot vector with fallback of NMI classes to their ordinary classes.
    always_comb begin
        pend             = '0;
        pend[SLOT_FIQ]   = fiq_req;
        pend[SLOT_NMI]   = sp_on_phys && nmi_req;
        pend[SLOT_IRQ]   = irq_req || (!sp_on_phys && nmi_req);
        pend[SLOT_VINMI] = sp_on_virt && vinmi_lvl;
        pend[SLOT_VIRQ]  = virq_lvl || (!sp_on_virt && vinmi_lvl);
        pend[SLOT_VFNMI] = sp_on_virt && vfnmi_lvl;
        pend[SLOT_VFIQ]  = vfiq_lvl || (!sp_on_virt && vfnmi_lvl);
    end
endmodule

// File: rtl/sprio_pick.sv
// Module: sprio_pick
// Fixed-priority picker: the lowest-numbered active candidate wins and its
// code is its index plus one; no active candidate gives code zero.
// Assumes: N + 1 fits in CW bits.
module sprio_pick #(
    parameter int N  = 7,
    parameter int CW = 3
) (
    input  logic [N-1:0]  cand,
    output logic [CW-1:0] code
);
    logic [N:0]   seen;
    logic [N-1:0] win;

    assign seen[0] = 1'b0;

    // Ripple chain: a candidate wins if no earlier one is active.
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign win[g]    = cand[g] && !seen[g];
        assign seen[g+1] = seen[g] || cand[g];
    end

    // Encode the single winner into its code.
    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) code = code | CW'(i + 1);
        end
    end
endmodule

// File: rtl/sprio_arb.sv
// Module: sprio_arb (top)
// Interrupt acceptance and selection with a superpriority class. Forms the
// pending classes, applies level, status and routing masks, picks the
// first unmasked class in priority order and registers its code.
// Assumes: virtual classes target level 1; physical classes share one
// target level; synchronous active-low reset.
module sprio_arb
    import sprio_pkg::*;
#(
    parameter int NLVL    = 4,
    parameter bit HAS_NMI = 1'b1,
    localparam int LW     = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nmi_req,
    input  logic            irq_req,
    input  logic            fiq_req,
    input  logic            virq_line,
    input  logic            vfiq_line,
    input  logic            vinmi_line,
    input  logic            vfnmi_line,
    input  logic [LW-1:0]   cur_lvl,
    input  logic [LW-1:0]   phys_tgt_lvl,
    input  logic            st_mask_i,
    input  logic            st_mask_f,
    input  logic            st_allint,
    input  logic            st_spsel,
    input  logic [NLVL-1:0] sp_en,
    input  logic [NLVL-1:0] spm_en,
    input  logic            hyp_imo,
    input  logic            hyp_fmo,
    input  logic            hyp_tge,
    input  logic            hyp_vi,
    input  logic            hyp_vf,
    input  logic            hyp_vinmi,
    input  logic            hyp_vfnmi,
    output logic [2:0]      exc_code,
    output logic            exc_valid
);
    localparam int NTGT          = 2;   // 0: physical target, 1: virtual target
    localparam logic [LW-1:0] VLVL = LW'(1);

    logic [LW-1:0]       tgt   [NTGT];
    logic [NTGT-1:0]     lvl_ok, sp_on, all_mask;
    logic [NUM_CAND-1:0] pend, unmask, cand;
    logic [2:0]          pick_code;

    assign tgt[0] = phys_tgt_lvl;
    assign tgt[1] = VLVL;

    // One gate per target level class.
    for (genvar t = 0; t < NTGT; t++) begin : g_gate
        sprio_gate #(.NLVL(NLVL), .HAS_NMI(HAS_NMI)) u_gate (
            .cur_lvl   (cur_lvl),
            .tgt_lvl   (tgt[t]),
            .sp_en     (sp_en),
            .spm_en    (spm_en),
            .st_allint (st_allint),
            .st_spsel  (st_spsel),
            .lvl_ok    (lvl_ok[t]),
            .sp_on     (sp_on[t]),
            .all_mask  (all_mask[t])
        );
    end

    sprio_pend u_pend (
        .nmi_req    (nmi_req),
        .irq_req    (irq_req),
        .fiq_req    (fiq_req),
        .virq_line  (virq_line),
        .vfiq_line  (vfiq_line),
        .vinmi_line (vinmi_line),
        .vfnmi_line (vfnmi_line),
        .hyp_vi     (hyp_vi),
        .hyp_vf     (hyp_vf),
        .hyp_vinmi  (hyp_vinmi),
        .hyp_vfnmi  (hyp_vfnmi),
        .sp_on_phys (sp_on[0]),
        .sp_on_virt (sp_on[1]),
        .pend       (pend)
    );

    // Per-class unmask conditions from level, status and routing bits.
    always_comb begin
        logic p_ok, v_irq_rt, v_fiq_rt;
        p_ok     = lvl_ok[0] && !all_mask[0];
        v_irq_rt = lvl_ok[1] && !all_mask[1] && hyp_imo && !hyp_tge;
        v_fiq_rt = lvl_ok[1] && !all_mask[1] && hyp_fmo && !hyp_tge;
        unmask             = '0;
        unmask[SLOT_NMI]   = p_ok;
        unmask[SLOT_FIQ]   = p_ok && !st_mask_f;
        unmask[SLOT_IRQ]   = p_ok && !st_mask_i;
        unmask[SLOT_VINMI] = v_irq_rt;
        unmask[SLOT_VFNMI] = v_fiq_rt;
        unmask[SLOT_VIRQ]  = v_irq_rt && !st_mask_i;
        unmask[SLOT_VFIQ]  = v_fiq_rt && !st_mask_f;
    end

    assign cand = pend & unmask;

    sprio_pick #(.N(NUM_CAND), .CW(3)) u_pick (
        .cand (cand),
        .code (pick_code)
    );

    // Output register: selected code and valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_code  <= EXC_NONE;
            exc_valid <= 1'b0;
        end else begin
            exc_code  <= pick_code;
            exc_valid <= (pick_code != EXC_NONE);
        end
    end
endmodule

// File: rtl/sprio_arb_chk.sv
// Module: sprio_arb_chk
// Property checker bound to sprio_arb; relates its ports across one edge.
module sprio_arb_chk
    import sprio_pkg::*;
#(
    parameter int NLVL    = 4,
    parameter bit HAS_NMI = 1'b1,
    localparam int LW     = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            nmi_req,
    input logic            irq_req,
    input logic            fiq_req,
    input logic            virq_line,
    input logic            vfiq_line,
    input logic            vinmi_line,
    input logic            vfnmi_line,
    input logic [LW-1:0]   cur_lvl,
    input logic [LW-1:0]   phys_tgt_lvl,
    input logic            st_mask_i,
    input logic            st_mask_f,
    input logic            st_allint,
    input logic            st_spsel,
    input logic [NLVL-1:0] sp_en,
    input logic [NLVL-1:0] spm_en,
    input logic            hyp_imo,
    input logic            hyp_fmo,
    input logic            hyp_tge,
    input logic            hyp_vi,
    input logic            hyp_vf,
    input logic            hyp_vinmi,
    input logic            hyp_vfnmi,
    input logic [2:0]      exc_code,
    input logic            exc_valid
);
    logic phys_out, virt_out;
    assign phys_out = (exc_code == EXC_NMI) || (exc_code == EXC_FIQ) || (exc_code == EXC_IRQ);
    assign virt_out = exc_valid && !phys_out;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!exc_valid && exc_code == EXC_NONE));                                      // R11
    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (exc_valid == (exc_code != EXC_NONE)));                                        // R11
    AST_PHYS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_tgt_lvl < cur_lvl) |=> !phys_out);                                                // R1
    AST_VIRT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl > LW'(1)) |=> !virt_out);                                                      // R1
    AST_ALLINT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_NMI && sp_en[phys_tgt_lvl] && cur_lvl == phys_tgt_lvl && st_allint) |=> !phys_out); // R2
    AST_NMI_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_NMI && nmi_req && sp_en[phys_tgt_lvl] && phys_tgt_lvl > cur_lvl)
        |=> (exc_code == EXC_NMI));                                                            // R3
    AST_VIRT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (hyp_tge || (!hyp_imo && !hyp_fmo)) |=> !virt_out);                                     // R5
    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_req && !irq_req && !fiq_req && !virq_line && !vfiq_line && !vinmi_line &&
         !vfnmi_line && !hyp_vi && !hyp_vf) |=> !exc_valid);                                     // R8
endmodule

bind sprio_arb sprio_arb_chk #(.NLVL(NLVL), .HAS_NMI(HAS_NMI)) u_chk (.*);

// File: tb/sprio_arb_test.sv
module sprio_arb_test;
    localparam int CLK_PERIOD = 10;
    localparam int NLVL = 4;
    localparam int LW   = 2;
    localparam bit HAS  = 1'b1;
    localparam int NRAND = 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_req, irq_req, fiq_req, virq_line, vfiq_line, vinmi_line, vfnmi_line;
    logic [LW-1:0] cur_lvl, phys_tgt_lvl;
    logic st_mask_i, st_mask_f, st_allint, st_spsel;
    logic [NLVL-1:0] sp_en, spm_en;
    logic hyp_imo, hyp_fmo, hyp_tge, hyp_vi, hyp_vf, hyp_vinmi, hyp_vfnmi;
    logic [2:0] exc_code;
    logic exc_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprio_arb #(.NLVL(NLVL), .HAS_NMI(HAS)) uut (.*);

    task automatic clear_in();
        {nmi_req, irq_req, fiq_req, virq_line, vfiq_line, vinmi_line, vfnmi_line} = '0;
        cur_lvl = '0; phys_tgt_lvl = '0;
        {st_mask_i, st_mask_f, st_allint, st_spsel} = '0;
        sp_en = '0; spm_en = '0;
        {hyp_imo, hyp_fmo, hyp_tge, hyp_vi, hyp_vf, hyp_vinmi, hyp_vfnmi} = '0;
    endtask

    // Compare outputs against an expected code; called on a falling edge.
    task automatic check_out(input logic [2:0] exp, input string tag);
        total++;
        if (exc_code !== exp || exc_valid !== (exp != 3'd0)) begin
            bad++;
            $display("FAIL %s: code=%0d valid=%0d expected code=%0d valid=%0d",
                     tag, exc_code, exc_valid, exp, (exp != 3'd0));
        end
    endtask

    // Inputs were set on this falling edge; result due after the next rising edge.
    task automatic step_check(input logic [2:0] exp, input string tag);
        @(negedge clk);
        check_out(exp, tag);
    endtask

    // Reference selection written from the requirements text.
    function automatic logic [2:0] ref_code();
        logic spp, spv, amp, amv, pok, vok;
        logic n_l, i_l, vin_l, vfn_l, vi_l, vf_l;
        spp = HAS && sp_en[phys_tgt_lvl];
        spv = HAS && sp_en[1];
        amp = spp && (cur_lvl == phys_tgt_lvl) && (st_allint || (spm_en[phys_tgt_lvl] && st_spsel));
        amv = spv && (cur_lvl == 2'd1) && (st_allint || (spm_en[1] && st_spsel));
        pok = (phys_tgt_lvl >= cur_lvl) && !amp;
        vok = (cur_lvl <= 2'd1) && !amv && !hyp_tge;
        vin_l = (hyp_vi && hyp_vinmi) || vinmi_line;
        vfn_l = (hyp_vf && hyp_vfnmi) || vfnmi_line;
        vi_l  = (hyp_vi && !hyp_vinmi) || virq_line;
        vf_l  = (hyp_vf && !hyp_vfnmi) || vfiq_line;
        n_l = nmi_req; i_l = irq_req;
        if (!spp) begin i_l = i_l || n_l; n_l = 1'b0; end
        if (!spv) begin
            vi_l = vi_l || vin_l; vin_l = 1'b0;
            vf_l = vf_l || vfn_l; vfn_l = 1'b0;
        end
        if (n_l && pok) return 3'd1;
        if (vin_l && vok && hyp_imo) return 3'd2;
        if (vfn_l && vok && hyp_fmo) return 3'd3;
        if (fiq_req && pok && !st_mask_f) return 3'd4;
        if (i_l && pok && !st_mask_i) return 3'd5;
        if (vi_l && vok && hyp_imo && !st_mask_i) return 3'd6;
        if (vf_l && vok && hyp_fmo && !st_mask_f) return 3'd7;
        return 3'd0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        clear_in();
        nmi_req = 1'b1; irq_req = 1'b1; sp_en = '1;
        repeat (3) @(negedge clk);
        check_out(3'd0, "R11 reset holds outputs clear");
        rst_n = 1'b1;
        step_check(3'd1, "R11 one edge after reset release");

        // R3: NMI ignores I and F
        clear_in(); sp_en = '1; cur_lvl = 2'd1; phys_tgt_lvl = 2'd1;
        nmi_req = 1'b1; st_mask_i = 1'b1; st_mask_f = 1'b1;
        step_check(3'd1, "R3 NMI with I and F set");
        // R2: all-interrupt mask via status bit, via stack select, and when levels differ
        st_allint = 1'b1;
        step_check(3'd0, "R2 allint masks NMI at same level");
        st_allint = 1'b0; spm_en[1] = 1'b1; st_spsel = 1'b1;
        step_check(3'd0, "R2 sp mask with stack select masks NMI");
        st_spsel = 1'b0;
        step_check(3'd1, "R2 sp mask without stack select leaves NMI");
        cur_lvl = 2'd0; st_allint = 1'b1;
        step_check(3'd1, "R2 mask inactive when current below target");

        // R4: IRQ/FIQ masks
        clear_in(); sp_en = '1; irq_req = 1'b1; st_mask_i = 1'b1;
        step_check(3'd0, "R4 IRQ blocked by I");
        st_mask_i = 1'b0;
        step_check(3'd5, "R4 IRQ taken with I clear");
        st_allint = 1'b1;
        step_check(3'd0, "R4 IRQ blocked by all-interrupt mask");
        clear_in(); fiq_req = 1'b1; st_mask_i = 1'b1;
        step_check(3'd4, "R4 FIQ taken with F clear");

        // R1: lower target rejected
        clear_in(); cur_lvl = 2'd2; phys_tgt_lvl = 2'd1; irq_req = 1'b1;
        step_check(3'd0, "R1 physical target below current");
        clear_in(); cur_lvl = 2'd2; hyp_imo = 1'b1; virq_line = 1'b1;
        step_check(3'd0, "R1 virtual target below current");

        // R5: virtual NMI routing
        clear_in(); sp_en = '1; cur_lvl = 2'd1; hyp_imo = 1'b1; vinmi_line = 1'b1; st_mask_i = 1'b1;
        step_check(3'd2, "R5 virtual IRQ-NMI ignores I");
        hyp_tge = 1'b1;
        step_check(3'd0, "R5 virtual IRQ-NMI blocked by TGE");
        clear_in(); sp_en = '1; hyp_imo = 1'b1; vfnmi_line = 1'b1;
        step_check(3'd0, "R5 virtual FIQ-NMI needs FMO");
        hyp_fmo = 1'b1; cur_lvl = 2'd1; st_allint = 1'b1;
        step_check(3'd0, "R5 virtual FIQ-NMI blocked by all-interrupt mask");

        // R6: virtual IRQ/FIQ
        clear_in(); hyp_imo = 1'b1; virq_line = 1'b1;
        step_check(3'd6, "R6 virtual IRQ routed");
        st_mask_i = 1'b1;
        step_check(3'd0, "R6 virtual IRQ blocked by I");
        clear_in(); vfiq_line = 1'b1; hyp_imo = 1'b1;
        step_check(3'd0, "R6 virtual FIQ needs FMO");

        // R7: priority order
        clear_in(); sp_en = '1; hyp_imo = 1'b1; hyp_fmo = 1'b1;
        nmi_req = 1'b1; fiq_req = 1'b1; vinmi_line = 1'b1;
        step_check(3'd1, "R7 NMI over virtual NMI and FIQ");
        nmi_req = 1'b0; vfnmi_line = 1'b1;
        step_check(3'd2, "R7 virtual IRQ-NMI over virtual FIQ-NMI");
        vinmi_line = 1'b0; vfnmi_line = 1'b0; irq_req = 1'b1;
        step_check(3'd4, "R7 FIQ over IRQ");
        fiq_req = 1'b0; irq_req = 1'b0; virq_line = 1'b1; vfiq_line = 1'b1;
        step_check(3'd6, "R7 virtual IRQ over virtual FIQ");

        // R8 and R10: injection forms NMI levels, not plain virtual classes
        clear_in(); sp_en = '1; hyp_imo = 1'b1; hyp_vi = 1'b1; hyp_vinmi = 1'b1;
        step_check(3'd2, "R8 R10 injected virtual IRQ-NMI");
        clear_in(); sp_en = '1; hyp_fmo = 1'b1; hyp_vf = 1'b1; hyp_vfnmi = 1'b1;
        step_check(3'd3, "R8 R10 injected virtual FIQ-NMI");
        hyp_vfnmi = 1'b0;
        step_check(3'd7, "R8 plain injected virtual FIQ");

        // R9: fallback with superpriority off
        clear_in(); nmi_req = 1'b1; st_mask_i = 1'b1;
        step_check(3'd0, "R9 NMI falls back to IRQ and obeys I");
        st_mask_i = 1'b0;
        step_check(3'd5, "R9 NMI reported as IRQ");
        clear_in(); hyp_imo = 1'b1; hyp_vi = 1'b1; hyp_vinmi = 1'b1;
        step_check(3'd6, "R9 virtual IRQ-NMI reported as virtual IRQ");

        // R7 sweep over pseudo-random input patterns
        seed = 32'h1234_5679;
        for (int n = 0; n < NRAND; n++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            {nmi_req, irq_req, fiq_req, virq_line, vfiq_line, vinmi_line, vfnmi_line} = seed[6:0];
            cur_lvl = seed[8:7]; phys_tgt_lvl = seed[10:9];
            {st_mask_i, st_mask_f, st_allint, st_spsel} = seed[14:11];
            sp_en = seed[18:15]; spm_en = seed[22:19];
            {hyp_imo, hyp_fmo, hyp_tge, hyp_vi, hyp_vf, hyp_vinmi, hyp_vfnmi} = seed[29:23];
            step_check(ref_code(), "R7 sweep selection");
        end

        // R11: reset mid-run clears outputs
        clear_in(); irq_req = 1'b1; rst_n = 1'b0;
        step_check(3'd0, "R11 synchronous reset clears");
        rst_n = 1'b1;
        step_check(3'd5, "R11 resumes after reset");

        finish_run();
    end
endmodule